// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window through which a host processor hands commands to an embedded power controller and collects the answers. The host sees a flat 32-bit register bus with an address, a write strobe, a read strobe, a byte-read qualifier and write data. Combinational read data comes back in the same cycle. Four regions live in that window:
- a write-only command word;
- a read-only status word;
- a block of outgoing payload words that the host writes;
- a response area that the host reads.

The response area is readable either as whole words or as single bytes.

Writing the command word starts a handshake. The block latches the command fields, marks itself busy and pulses a new-command interrupt toward the controller. The controller reads the latched fields and the payload words, optionally fills the response area, and pulses a done strobe with an error flag, an error code and an initiator tag. Busy then drops. If the command asked for it, a one-cycle completion pulse goes back to the host. Nothing on the host side ever has to clear that pulse.

The handshake is a three-state machine:
- `ST_IDLE`: no command is pending.
- `ST_WAIT`: a command is pending and busy is high.
- `ST_REPORT`: a one-cycle state after completion. Busy is already low, and the completion pulse is driven here.

The transitions are:
- accept: `ST_IDLE` to `ST_WAIT` on a command write.
- finish: `ST_WAIT` to `ST_REPORT` on the controller's done strobe.
- settle: `ST_REPORT` to `ST_IDLE` with no command write.
- chain: `ST_REPORT` to `ST_WAIT` when a command write lands in that cycle.

Top module: `mbox_regs`

## Requirements
- R1: A host write to offset 0x00 while busy is low is accepted. Busy (status bit 0) reads 1 from the next cycle. `c_cmd_irq` is high for exactly that one cycle. `c_code`, `c_sub` and `c_size` then show the written bits [7:0], [15:12] and [23:16]. A write in the `ST_REPORT` cycle is also accepted.
- R2: Once set, busy stays 1 until the controller pulses `c_done`. Busy reads 0 in the cycle after the `c_done` edge.
- R3: At the done edge the block captures `c_err`, `c_ecode` and `c_init_id` into status bit 1, bits [31:24] and bits [23:16]. An accepted command clears all three to zero.
- R4: In the cycle where busy first reads 0 after completion, `h_done_irq` is high for exactly one cycle, but only if bit 8 of the accepted command word was 1. Bits [11:9] and [31:24] of the command word have no effect on it.
- R5: A command write while busy is 1 is dropped, so the latched fields are unchanged and no `c_cmd_irq` pulse occurs. It sets the sticky overrun flag at status bit 2, which survives completion and clears on the next accepted command.
- R6: Host word writes to offsets 0x80 + 4*i, for i = 0 to 4, store the data in payload word i, which appears on `c_wbuf[32*i +: 32]`.
- R7: When `c_rsp_we` is high at an edge, word `c_rsp_idx` of the response area takes `c_rsp_data`. The host reads response word i at 0x90 + 4*i with `h_byte` = 0. With `h_byte` = 1, a read at 0x90 + k returns byte k, taken little-endian as bits [8*(k%4) +: 8] of word k/4, in bits [7:0] with zeros above.
- R8: Host reads of write-only locations (0x00 and 0x80 to 0x8F) return zero. Host writes to status (0x04) change nothing. A host write at 0x90 lands in payload word 4 and leaves the response word at the same offset untouched.
- R9: Status bits [15:12] echo the sub-id of the last accepted command. Bit 3 and bits [11:4] read 0.
- R10: After reset, status reads 0 and both interrupt outputs are low.
- R11: A `c_done` pulse while busy is 0 changes nothing visible: status and `h_done_irq` stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | AW (8) | Host byte address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_byte | input | 1 | Byte-wide read of the response area when 1 |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, same cycle |
| h_done_irq | output | 1 | One-cycle completion pulse to the host |
| c_cmd_irq | output | 1 | One-cycle new-command pulse to the controller |
| c_code | output | 8 | Latched command code |
| c_sub | output | 4 | Latched command sub-id |
| c_size | output | 8 | Latched payload byte count |
| c_wbuf | output | 32*WB_WORDS (160) | Payload words, word 0 in the low bits |
| c_rsp_we | input | 1 | Response word write enable |
| c_rsp_idx | input | log2(RB_WORDS) (2) | Response word index |
| c_rsp_data | input | 32 | Response word data |
| c_done | input | 1 | Controller completion strobe |
| c_err | input | 1 | Error flag reported with completion |
| c_ecode | input | 8 | Error code reported with completion |
| c_init_id | input | 8 | Initiator tag reported with completion |

## Verification
The handshake is driven with a table of four command words that differ in code, sub-id and size, in whether bit 8 is set, and in whether the reserved bits [11:9] and [31:24] are set. Each is paired with a completion that carries or omits an error. This separates a completion pulse decoded from the true request bit from one decoded from a neighbouring reserved bit, and it shows whether error fields are captured at done or left stale. Directed patterns then cover three cases:
- a second command while busy, to tell a dropped write from an overwriting one;
- a done strobe with nothing pending;
- a command written in the single cycle after completion.

The shared 0x90 offset is written by the host and read back from the response side, to show that the write and read halves stay separate. All sixteen response bytes are read individually to confirm the byte order.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
    localparam int DW = 32;

    // Host-visible byte offsets (fixed by the software contract)
    localparam logic [7:0] CMD_OFS  = 8'h00;
    localparam logic [7:0] STAT_OFS = 8'h04;
    localparam logic [7:0] WB_BASE  = 8'h80;
    localparam logic [7:0] RB_BASE  = 8'h90;

    // Command word field positions
    localparam int CODE_LSB = 0;
    localparam int IOC_BIT  = 8;
    localparam int SUB_LSB  = 12;
    localparam int SIZE_LSB = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_REPORT = 2'd2
    } hs_state_t;

    typedef struct packed {
        logic [7:0] ecode;
        logic [7:0] init;
        logic [3:0] sub;
        logic [8:0] zero;
        logic       ovr;
        logic       err;
        logic       busy;
    } status_t;
endpackage

// File: rtl/mbox_hs_fsm.sv
`timescale 1ns/1ps
module mbox_hs_fsm
    import mbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_code,
    input  logic       cmd_ioc,
    input  logic [3:0] cmd_sub,
    input  logic [7:0] cmd_size,
    input  logic       c_done,
    input  logic       c_err,
    input  logic [7:0] c_ecode,
    input  logic [7:0] c_init,
    output logic       busy,
    output logic       err,
    output logic       overrun,
    output logic [3:0] sub,
    output logic [7:0] code,
    output logic [7:0] size,
    output logic [7:0] init,
    output logic [7:0] ecode,
    output logic       cmd_irq,
    output logic       done_irq
);
    hs_state_t state_q, state_d;
    logic      ioc_q;
    logic      accept;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, finish, settle, chain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_wr) state_d = ST_WAIT;
            ST_WAIT:   if (c_done) state_d = ST_REPORT;
            ST_REPORT: state_d = cmd_wr ? ST_WAIT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign accept = cmd_wr && (state_q != ST_WAIT);

    // Outputs decoded from state
    always_comb begin
        busy     = 1'b0;
        done_irq = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_WAIT:   busy = 1'b1;
            ST_REPORT: done_irq = ioc_q;
            default:   ;
        endcase
    end

    // Latched command and completion fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code    <= '0;
            sub     <= '0;
            size    <= '0;
            ioc_q   <= 1'b0;
            err     <= 1'b0;
            ecode   <= '0;
            init    <= '0;
            overrun <= 1'b0;
            cmd_irq <= 1'b0;
        end else begin
            cmd_irq <= accept;
            if (accept) begin
                code    <= cmd_code;
                sub     <= cmd_sub;
                size    <= cmd_size;
                ioc_q   <= cmd_ioc;
                err     <= 1'b0;
                ecode   <= '0;
                init    <= '0;
                overrun <= 1'b0;
            end else if (cmd_wr) begin
                overrun <= 1'b1;
            end
            if (state_q == ST_WAIT && c_done) begin
                err   <= c_err;
                ecode <= c_ecode;
                init  <= c_init;
            end
        end
    end

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> (busy && cmd_irq));
    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !c_done) |=> busy);
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);
    // R4
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $past(busy && c_done));
    // R5
    overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> (overrun && $stable(code) && !cmd_irq));
    // R11
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && c_done && !cmd_wr) |=> (!busy && !done_irq));
endmodule

// File: rtl/mbox_wbuf.sv
`timescale 1ns/1ps
module mbox_wbuf #(
    parameter int WORDS = 5,
    parameter int DW    = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IW-1:0]       idx,
    input  logic [DW-1:0]       wdata,
    output logic [WORDS*DW-1:0] words
);
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        q <= '0;
            else if (we && idx == IW'(i))      q <= wdata;
        end
        assign words[i*DW +: DW] = q;
    end

    // R6
    wbuf_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(idx) < WORDS));
endmodule

// File: rtl/mbox_rbuf.sv
`timescale 1ns/1ps
module mbox_rbuf #(
    parameter int WORDS = 4,
    parameter int DW    = 32,
    localparam int IW   = $clog2(WORDS),
    localparam int BW   = $clog2(WORDS * DW / 8)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [BW-1:0] raddr,
    output logic [DW-1:0] rd_word,
    output logic [7:0]    rd_byte
);
    logic [WORDS*DW-1:0] flat;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     q <= '0;
            else if (we && widx == IW'(i))  q <= wdata;
        end
        assign flat[i*DW +: DW] = q;
    end

    logic [IW-1:0] ridx;
    logic [1:0]    boff;
    assign ridx    = raddr[BW-1:2];
    assign boff    = raddr[1:0];
    assign rd_word = flat[ridx*DW +: DW];
    assign rd_byte = rd_word[{boff, 3'b000} +: 8];

    // R7
    rbuf_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && raddr[BW-1:2] == widx) |=> (rd_word == $past(wdata)));
endmodule

// File: rtl/mbox_regs.sv
`timescale 1ns/1ps
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int AW       = 8,
    parameter int WB_WORDS = 5,
    parameter int RB_WORDS = 4,
    localparam int RIW     = $clog2(RB_WORDS),
    localparam int WIW     = $clog2(WB_WORDS),
    localparam int RBW     = $clog2(RB_WORDS * 4)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          h_addr,
    input  logic                   h_wr,
    input  logic                   h_rd,
    input  logic                   h_byte,
    input  logic [DW-1:0]          h_wdata,
    output logic [DW-1:0]          h_rdata,
    output logic                   h_done_irq,
    output logic                   c_cmd_irq,
    output logic [7:0]             c_code,
    output logic [3:0]             c_sub,
    output logic [7:0]             c_size,
    output logic [WB_WORDS*DW-1:0] c_wbuf,
    input  logic                   c_rsp_we,
    input  logic [RIW-1:0]         c_rsp_idx,
    input  logic [DW-1:0]          c_rsp_data,
    input  logic                   c_done,
    input  logic                   c_err,
    input  logic [7:0]             c_ecode,
    input  logic [7:0]             c_init_id
);
    localparam logic [AW-1:0] WB_BYTES = AW'(WB_WORDS * 4);
    localparam logic [AW-1:0] RB_BYTES = AW'(RB_WORDS * 4);

    // Address decode
    logic [AW-1:0] woff, roff;
    logic          cmd_wr, wb_we, rb_hit, stat_hit;
    assign woff     = h_addr - AW'(WB_BASE);
    assign roff     = h_addr - AW'(RB_BASE);
    assign cmd_wr   = h_wr && (h_addr == AW'(CMD_OFS));
    assign wb_we    = h_wr && (woff < WB_BYTES) && (woff[1:0] == 2'b00);
    assign rb_hit   = roff < RB_BYTES;
    assign stat_hit = h_addr == AW'(STAT_OFS);

    logic       busy, err, ovr;
    logic [7:0] init_q, ecode_q;
    logic [3:0] sub_q;

    mbox_hs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_code (h_wdata[CODE_LSB +: 8]),
        .cmd_ioc  (h_wdata[IOC_BIT]),
        .cmd_sub  (h_wdata[SUB_LSB +: 4]),
        .cmd_size (h_wdata[SIZE_LSB +: 8]),
        .c_done   (c_done),
        .c_err    (c_err),
        .c_ecode  (c_ecode),
        .c_init   (c_init_id),
        .busy     (busy),
        .err      (err),
        .overrun  (ovr),
        .sub      (sub_q),
        .code     (c_code),
        .size     (c_size),
        .init     (init_q),
        .ecode    (ecode_q),
        .cmd_irq  (c_cmd_irq),
        .done_irq (h_done_irq)
    );
    assign c_sub = sub_q;

    mbox_wbuf #(.WORDS(WB_WORDS), .DW(DW)) u_wbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_we),
        .idx   (woff[WIW+1:2]),
        .wdata (h_wdata),
        .words (c_wbuf)
    );

    logic [DW-1:0] rb_word;
    logic [7:0]    rb_byte;

    mbox_rbuf #(.WORDS(RB_WORDS), .DW(DW)) u_rbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (c_rsp_we),
        .widx    (c_rsp_idx),
        .wdata   (c_rsp_data),
        .raddr   (roff[RBW-1:0]),
        .rd_word (rb_word),
        .rd_byte (rb_byte)
    );

    status_t stat;
    always_comb begin
        stat       = '0;
        stat.busy  = busy;
        stat.err   = err;
        stat.ovr   = ovr;
        stat.sub   = sub_q;
        stat.init  = init_q;
        stat.ecode = ecode_q;
    end

    // Host read mux: write-only and unmapped locations return zero
    always_comb begin
        h_rdata = '0;
        if (h_rd) begin
            if (stat_hit)    h_rdata = stat;
            else if (rb_hit) h_rdata = h_byte ? {24'h0, rb_byte} : rb_word;
        end
    end

    // R8
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && h_addr == AW'(CMD_OFS)) |-> (h_rdata == '0));
    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!h_done_irq && !c_cmd_irq));
endmodule

// File: tb/mbox_regs_test.sv
`timescale 1ns/1ps
module mbox_regs_test;
    localparam int AW = 8, WBW = 5, RBW = 4, DW = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  h_addr = '0;
    logic           h_wr = 1'b0, h_rd = 1'b0, h_byte = 1'b0;
    logic [DW-1:0]  h_wdata = '0;
    logic [DW-1:0]  h_rdata;
    logic           h_done_irq, c_cmd_irq;
    logic [7:0]     c_code, c_size;
    logic [3:0]     c_sub;
    logic [WBW*DW-1:0] c_wbuf;
    logic           c_rsp_we = 1'b0;
    logic [1:0]     c_rsp_idx = '0;
    logic [DW-1:0]  c_rsp_data = '0;
    logic           c_done = 1'b0, c_err = 1'b0;
    logic [7:0]     c_ecode = '0, c_init_id = '0;

    always #2.5 clk = ~clk;

    mbox_regs uut (.*);

    int  checks = 0, errors = 0;
    bit  ended = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #500000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        h_addr = a; h_wdata = d; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, input logic b, output logic [31:0] v);
        h_addr = a; h_byte = b; h_rd = 1'b1;
        #0.5;
        v = h_rdata;
        h_rd = 1'b0; h_byte = 1'b0;
    endtask

    task automatic ctrl_done(input logic e, input logic [7:0] ec, input logic [7:0] id);
        c_done = 1'b1; c_err = e; c_ecode = ec; c_init_id = id;
        @(negedge clk);
        c_done = 1'b0; c_err = 1'b0; c_ecode = '0; c_init_id = '0;
    endtask

    task automatic rsp_write(input logic [1:0] i, input logic [31:0] d);
        c_rsp_we = 1'b1; c_rsp_idx = i; c_rsp_data = d;
        @(negedge clk);
        c_rsp_we = 1'b0;
    endtask

    function automatic logic [31:0] st(input logic b, input logic e, input logic o,
                                       input logic [3:0] s, input logic [7:0] id,
                                       input logic [7:0] ec);
        return {ec, id, s, 8'h00, 1'b0, o, e, b};
    endfunction

    // {command word, done error, error code, initiator tag}
    localparam logic [48:0] VEC [0:3] = '{
        {32'h000310FF, 1'b0, 8'h00, 8'h11},
        {32'h001421F4, 1'b1, 8'h5A, 8'h22},
        {32'hAB04F1EF, 1'b0, 8'h00, 8'h33},
        {32'h00000EF8, 1'b1, 8'hC3, 8'h44}
    };

    logic [31:0] rv, last_st;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        host_read(8'h04, 1'b0, rv);
        chk("R10 status", rv, 32'h0);
        chk("R10 irqs", {h_done_irq, c_cmd_irq}, 0);

        // Table-driven handshake
        for (int k = 0; k < 4; k++) begin
            logic [31:0] cw;
            cw = VEC[k][48:17];
            host_write(8'h00, cw);
            chk("R1 cmd_irq", c_cmd_irq, 1);
            chk("R1 code", c_code, cw[7:0]);
            chk("R1 sub", c_sub, cw[15:12]);
            chk("R1 size", c_size, cw[23:16]);
            host_read(8'h04, 1'b0, rv);
            chk("R3 R9 status busy", rv, st(1, 0, 0, cw[15:12], 0, 0));
            @(negedge clk);
            chk("R1 cmd_irq one cycle", c_cmd_irq, 0);
            host_read(8'h04, 1'b0, rv);
            chk("R2 still busy", rv[0], 1);
            ctrl_done(VEC[k][16], VEC[k][15:8], VEC[k][7:0]);
            chk("R4 done_irq", h_done_irq, cw[8]);
            host_read(8'h04, 1'b0, rv);
            chk("R2 R3 R9 status done", rv,
                st(0, VEC[k][16], 0, cw[15:12], VEC[k][7:0], VEC[k][15:8]));
            last_st = rv;
            @(negedge clk);
            chk("R4 done_irq one cycle", h_done_irq, 0);
        end

        // R11 done with nothing pending
        ctrl_done(1'b1, 8'h77, 8'h99);
        chk("R11 no irq", h_done_irq, 0);
        host_read(8'h04, 1'b0, rv);
        chk("R11 status unchanged", rv, last_st);

        // R8 status write ignored
        host_write(8'h04, 32'hFFFFFFFF);
        host_read(8'h04, 1'b0, rv);
        chk("R8 status write ignored", rv, last_st);
        chk("R8 no cmd irq", c_cmd_irq, 0);

        // R6 payload words
        for (int i = 0; i < 5; i++)
            host_write(8'(8'h80 + 4 * i), 32'hA5000000 + 32'(i) * 32'h01010101);
        for (int i = 0; i < 5; i++)
            chk("R6 payload word", c_wbuf[32*i +: 32], 32'hA5000000 + 32'(i) * 32'h01010101);
        host_read(8'h80, 1'b0, rv);
        chk("R8 payload reads zero", rv, 0);
        host_read(8'h8C, 1'b0, rv);
        chk("R8 payload reads zero hi", rv, 0);
        host_read(8'h00, 1'b0, rv);
        chk("R8 command reads zero", rv, 0);

        // R7 response words and bytes
        for (int i = 0; i < 4; i++)
            rsp_write(2'(i), 32'h10203040 + 32'(i) * 32'h01010101);
        for (int i = 0; i < 4; i++) begin
            host_read(8'(8'h90 + 4 * i), 1'b0, rv);
            chk("R7 response word", rv, 32'h10203040 + 32'(i) * 32'h01010101);
        end
        for (int b = 0; b < 16; b++) begin
            logic [31:0] w;
            w = 32'h10203040 + 32'(b / 4) * 32'h01010101;
            host_read(8'(8'h90 + b), 1'b1, rv);
            chk("R7 response byte", rv, {24'h0, w[8*(b%4) +: 8]});
        end

        // R8 shared 0x90 offset
        host_write(8'h90, 32'hDEADBEEF);
        chk("R6 R8 payload word 4", c_wbuf[128 +: 32], 32'hDEADBEEF);
        host_read(8'h90, 1'b0, rv);
        chk("R8 response untouched", rv, 32'h10203040);

        // R5 overrun
        host_write(8'h00, 32'h00083011);
        @(negedge clk);
        host_write(8'h00, 32'h000450AA);
        chk("R5 dropped no irq", c_cmd_irq, 0);
        chk("R5 code kept", {c_size, c_sub, c_code}, {8'h08, 4'h3, 8'h11});
        host_read(8'h04, 1'b0, rv);
        chk("R5 overrun set", rv, st(1, 0, 1, 4'h3, 0, 0));
        ctrl_done(1'b0, 8'h00, 8'h05);
        chk("R4 no irq without request", h_done_irq, 0);
        host_read(8'h04, 1'b0, rv);
        chk("R5 overrun sticky", rv, st(0, 0, 1, 4'h3, 8'h05, 0));
        // R1 chain: command in the report cycle
        host_write(8'h00, 32'h00016122);
        chk("R1 chain accepted", c_cmd_irq, 1);
        host_read(8'h04, 1'b0, rv);
        chk("R5 overrun cleared", rv, st(1, 0, 0, 4'h6, 0, 0));
        chk("R1 chain fields", {c_size, c_sub, c_code}, {8'h01, 4'h6, 8'h22});
        @(negedge clk);
        ctrl_done(1'b0, 8'h00, 8'h00);
        chk("R4 irq on request", h_done_irq, 1);
        @(negedge clk);
        chk("R4 irq ends", h_done_irq, 0);

        finish_run();
    end
endmodule